// File: doc/BRIEF.md
# Power-Mode and Clock-Source Controller

This block decides how a small controller core is clocked. From a two-bit clock-source select field, an idle-enable bit, a one-cycle sleep strobe and a wake input, it produces four outputs: the active clock-source code, a CPU clock enable, a peripheral clock enable and a 3-bit code for the current mode. Three sources are supported: primary, secondary (a low-frequency timer oscillator) and an internal oscillator block. Each source reports through a running flag whether it is usable.

The block has seven modes. In the three run modes, CPU and peripherals are clocked from the active source. In the three idle modes, the CPU is gated off and the peripherals keep their source. In sleep, every clock is off. While the core is awake, a change of the select field moves to the new source on the next edge if that source is running. Otherwise the request is held as pending until the source comes up. The sleep strobe enters idle or sleep depending on the idle-enable bit at that cycle. All pins are plain level signals with no handshake. The block has no data stream, so no valid/ready interface applies.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released, until the first input-driven change, the block is in primary-run: mode 0, source code 00, both enables 1, pending 0 with select 00.
- R2: Select 00 requests the primary source, 01 the secondary, and 10 or 11 the internal block. The source code output is 00 for primary, 01 for secondary, 10 for internal and 11 when no source is active.
- R3: Outside sleep, if the requested source differs from the active one and its running flag (bit 0 primary, bit 1 secondary, bit 2 internal) is 1 at a clock edge, the source code shows the requested source after that edge.
- R4: If the requested source's running flag is 0, the active source is kept and the pending output is 1. The switch happens at the first edge at which the flag is 1. Pending is 0 whenever the requested and active sources match.
- R5: A sleep strobe in a run mode with idle-enable 1 gives idle after the edge: CPU enable 0, peripheral enable 1, source unchanged by the strobe.
- R6: A sleep strobe in a run mode with idle-enable 0 gives sleep after the edge: both enables 0, source code 11, mode 6.
- R7: In every run mode, both the CPU and peripheral enables are 1.
- R8: A wake input in idle or sleep gives, after the edge, the run mode of the active source with both enables 1.
- R9: A sleep strobe in idle or sleep has no effect on the mode class. Idle stays idle and sleep stays sleep.
- R10: The mode code is 0/1/2 for primary/secondary/internal run, 3/4/5 for primary/secondary/internal idle, and 6 for sleep.
- R11: In sleep the active source is frozen. A select change made during sleep stays pending and is applied after wake. In idle, source switches follow R3 and R4.
- R12: A wake input in a run mode has no effect. A sleep strobe with wake in the same run cycle enters idle or sleep as in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Requested clock-source select field |
| idle_en | input | 1 | 1: sleep strobe enters idle; 0: sleep strobe enters sleep |
| sleep_req | input | 1 | One-cycle sleep strobe |
| wake | input | 1 | Wake event, returns idle/sleep to run |
| src_running | input | 3 | Running flags: bit 0 primary, bit 1 secondary, bit 2 internal |
| src_sel | output | 2 | Active source code, 11 when none |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 3 | Current mode code |
| sel_pending | output | 1 | A requested source switch is waiting |

## Verification
The bench builds the block with its package defaults: three sources, a two-bit select field and a three-bit mode code. These defaults make all seven modes and all four select codes reachable, including the two codes that both name the internal block. Random running flags with a bias toward high, together with sparse strobes and wakes, exercise the corner cases. These include switches blocked and later released in run and idle, select changes frozen across sleep, and strobe and wake arriving in the same cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int NSRC   = 3;
  localparam int SEL_W  = 2;
  localparam int MODE_W = 3;

  localparam logic [SEL_W-1:0] SRC_PRI = 2'b00;
  localparam logic [SEL_W-1:0] SRC_SEC = 2'b01;
  localparam logic [SEL_W-1:0] SRC_INT = 2'b10;
  localparam logic [SEL_W-1:0] SRC_OFF = 2'b11;

  localparam logic [MODE_W-1:0] IDLE_BASE  = MODE_W'(NSRC);
  localparam logic [MODE_W-1:0] MODE_SLEEP = MODE_W'(2 * NSRC);

  typedef enum logic [1:0] {PH_RUN = 2'd0, PH_IDLE = 2'd1, PH_SLEEP = 2'd2} phase_t;
endpackage

// File: rtl/pmc_src_track.sv
module pmc_src_track
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  running,
  input  logic             freeze,
  output logic [SEL_W-1:0] cur,
  output logic             pending
);
  logic [SEL_W-1:0] req;
  logic             req_up;

  // Either code with the upper bit set names the internal block
  always_comb begin
    req = sel[1] ? SRC_INT : (sel[0] ? SRC_SEC : SRC_PRI);
    case (req)
      SRC_PRI: req_up = running[0];
      SRC_SEC: req_up = running[1];
      default: req_up = running[2];
    endcase
  end

  assign pending = (req != cur);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cur <= SRC_PRI;
    else if (!freeze && pending && req_up)
      cur <= req;
  end
endmodule

// File: rtl/pmc_phase_fsm.sv
module pmc_phase_fsm
  import pmc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sleep_req,
  input  logic   idle_en,
  input  logic   wake,
  output phase_t phase
);
  phase_t nxt;

  always_comb begin
    nxt = phase;
    case (phase)
      PH_RUN:  if (sleep_req) nxt = idle_en ? PH_IDLE : PH_SLEEP;
      default: if (wake) nxt = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_RUN;
    else        phase <= nxt;
  end
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
  import pmc_pkg::*;
(
  input  phase_t            phase,
  input  logic [SEL_W-1:0]  cur,
  output logic [SEL_W-1:0]  src_sel,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic [MODE_W-1:0] mode
);
  always_comb begin
    cpu_clk_en    = (phase == PH_RUN);
    periph_clk_en = (phase != PH_SLEEP);
    src_sel       = (phase == PH_SLEEP) ? SRC_OFF : cur;
    case (phase)
      PH_RUN:  mode = MODE_W'(cur);
      PH_IDLE: mode = IDLE_BASE + MODE_W'(cur);
      default: mode = MODE_SLEEP;
    endcase
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic              idle_en,
  input  logic              sleep_req,
  input  logic              wake,
  input  logic [NSRC-1:0]   src_running,
  output logic [SEL_W-1:0]  src_sel,
  output logic              cpu_clk_en,
  output logic              periph_clk_en,
  output logic [MODE_W-1:0] mode,
  output logic              sel_pending
);
  phase_t           phase;
  logic [SEL_W-1:0] cur;

  pmc_src_track u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (clk_sel),
    .running (src_running),
    .freeze  (phase == PH_SLEEP),
    .cur     (cur),
    .pending (sel_pending)
  );

  pmc_phase_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .idle_en   (idle_en),
    .wake      (wake),
    .phase     (phase)
  );

  pmc_out_dec u_dec (
    .phase         (phase),
    .cur           (cur),
    .src_sel       (src_sel),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .mode          (mode)
  );
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req,
  input logic              wake,
  input logic [NSRC-1:0]   src_running,
  input logic [SEL_W-1:0]  src_sel,
  input logic              cpu_clk_en,
  input logic              periph_clk_en,
  input logic [MODE_W-1:0] mode
);
  logic [NSRC-1:0] prev_run;
  always_ff @(posedge clk) prev_run <= src_running;

  logic in_idle, in_low;
  assign in_idle = (mode >= IDLE_BASE) && (mode < MODE_SLEEP);
  assign in_low  = (mode >= IDLE_BASE);

  a_r6_sleep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP) |-> (!cpu_clk_en && !periph_clk_en && src_sel == SRC_OFF));

  a_r5_idle_gates_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (!cpu_clk_en && periph_clk_en));

  a_r7_run_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
    (mode < IDLE_BASE) |-> (cpu_clk_en && periph_clk_en));

  a_r8_wake_to_run: assert property (@(posedge clk) disable iff (!rst_n)
    (in_low && wake) |=> (cpu_clk_en && periph_clk_en && mode < IDLE_BASE));

  a_r9_strobe_ignored_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && sleep_req && !wake) |=> ((mode >= IDLE_BASE) && (mode < MODE_SLEEP)));

  a_r9_strobe_ignored_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_SLEEP && !wake) |=> (mode == MODE_SLEEP));

  // R4: a source only becomes active if its flag was up at the switching edge
  a_r4_switch_needs_running: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_OFF && $past(src_sel) != SRC_OFF && src_sel != $past(src_sel))
      |-> prev_run[src_sel]);

  a_r10_mode_range: assert property (@(posedge clk) disable iff (!rst_n)
    mode <= MODE_SLEEP);
endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sleep_req     (sleep_req),
  .wake          (wake),
  .src_running   (src_running),
  .src_sel       (src_sel),
  .cpu_clk_en    (cpu_clk_en),
  .periph_clk_en (periph_clk_en),
  .mode          (mode)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] clk_sel;
  logic       idle_en, sleep_req, wake;
  logic [2:0] src_running;
  logic [1:0] src_sel;
  logic       cpu_clk_en, periph_clk_en, sel_pending;
  logic [2:0] mode;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state: phase 0 run, 1 idle, 2 sleep
  int m_ph = 0;
  int m_src = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .idle_en(idle_en),
    .sleep_req(sleep_req), .wake(wake), .src_running(src_running),
    .src_sel(src_sel), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
    .mode(mode), .sel_pending(sel_pending)
  );

  function automatic int req_of(logic [1:0] s);
    return s[1] ? 2 : int'(s[0]);
  endfunction

  function automatic int exp_mode();
    return (m_ph == 2) ? 6 : (m_ph == 1 ? 3 + m_src : m_src);
  endfunction

  function automatic int exp_sel();
    return (m_ph == 2) ? 3 : m_src;
  endfunction

  task automatic chk(string tag, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "mode", int'(mode), exp_mode());
    chk(tag, "src_sel", int'(src_sel), exp_sel());
    chk(tag, "cpu_clk_en", int'(cpu_clk_en), m_ph == 0 ? 1 : 0);
    chk(tag, "periph_clk_en", int'(periph_clk_en), m_ph != 2 ? 1 : 0);
    chk(tag, "sel_pending", int'(sel_pending), req_of(clk_sel) != m_src ? 1 : 0);
  endtask

  // Drive at negedge, advance model at posedge, check shortly after
  task automatic step(string tag, logic [1:0] s, logic ie, logic sl, logic wk, logic [2:0] run);
    int r;
    clk_sel = s; idle_en = ie; sleep_req = sl; wake = wk; src_running = run;
    @(posedge clk);
    r = req_of(s);
    if (m_ph != 2 && r != m_src && run[r]) m_src = r;
    if (m_ph == 0) begin
      if (sl) m_ph = ie ? 1 : 2;
    end else if (wk) m_ph = 0;
    #1;
    chk_all(tag);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20240611);
    rst_n = 0; clk_sel = 2'b00; idle_en = 0; sleep_req = 0; wake = 0; src_running = 3'b111;
    repeat (3) @(negedge clk);
    chk_all("R1");
    rst_n = 1;
    step("R1", 2'b00, 0, 0, 0, 3'b111);
    step("R12", 2'b00, 0, 0, 1, 3'b111);          // wake in run ignored
    step("R3", 2'b01, 0, 0, 0, 3'b111);           // to secondary
    step("R2", 2'b11, 0, 0, 0, 3'b111);           // 11 -> internal
    step("R2", 2'b10, 0, 0, 0, 3'b111);           // 10 -> internal, no change
    step("R4", 2'b00, 0, 0, 0, 3'b110);           // primary down: pending
    step("R4", 2'b00, 0, 0, 0, 3'b110);
    step("R4", 2'b00, 0, 0, 0, 3'b001);           // primary up: switch
    step("R5", 2'b00, 1, 1, 0, 3'b111);           // idle
    step("R9", 2'b00, 0, 1, 0, 3'b111);           // strobe in idle ignored
    step("R11", 2'b01, 1, 0, 0, 3'b111);          // switch allowed in idle
    step("R8", 2'b01, 1, 0, 1, 3'b111);           // wake -> secondary run
    step("R12", 2'b01, 0, 1, 1, 3'b111);          // strobe+wake in run -> sleep
    step("R6", 2'b10, 0, 0, 0, 3'b111);           // select during sleep frozen
    step("R9", 2'b10, 1, 1, 0, 3'b111);           // strobe in sleep ignored
    step("R11", 2'b10, 0, 0, 1, 3'b111);          // wake: run on secondary
    step("R11", 2'b10, 0, 0, 0, 3'b111);          // then switches to internal
    step("R10", 2'b10, 1, 1, 0, 3'b111);          // internal idle = 5
    step("R8", 2'b10, 0, 0, 1, 3'b111);
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] s;
      logic [2:0] run;
      s = clk_sel;
      if ($urandom_range(0, 4) == 0) s = 2'($urandom_range(0, 3));
      for (int b = 0; b < 3; b++) run[b] = ($urandom_range(0, 3) != 0);
      step("R3", s, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 6) == 0), run);
    end
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule